// File: doc/BRIEF.md
# Polyphase 9/7 Wavelet Analysis Stage

This block runs one level of the forward biorthogonal 9/7 wavelet transform along a single dimension. Samples arrive one per accepted cycle. Each frame is marked by a start flag, and its length is given alongside that flag. For every two input samples the block emits one low-pass (approximation) value and one high-pass (detail) value. It never computes the outputs that decimation would throw away.

The nine-sample neighbourhood of each output pair is split by position parity. Even-position samples meet the even-indexed coefficients and odd-position samples meet the odd-indexed ones. The four coefficient subsets work in parallel, one per pair of filter and phase. Each subset multiplies by distributed arithmetic: a bit-plane lookup of precomputed coefficient sums, followed by a shift-and-add tree.

Samples beyond either frame edge are replaced by a whole-sample mirror of the frame. The first and last pairs therefore need no padding from the caller. The upstream source streams frames of even length. It may insert idle cycles anywhere, and it may start a new frame in the cycle right after the previous frame's last sample.

Top module: `dwt97_analysis`

## Requirements
- R1: While reset is asserted, and until the first output pair is produced, `out_valid` and `out_last` are low.
- R2: A frame of N samples (N even, 8 <= N <= MAX_N) yields exactly N/2 output pairs, in increasing pair index, and an output never appears without a sample accepted two cycles earlier or an output in the previous cycle.
- R3: Low output of pair n equals floor((sum over k=-4..4 of h[k]*x[2n-k]) / 256). The coefficients are h[0]=154, h[±1]=68, h[±2]=-20, h[±3]=-4, h[±4]=7, and x is the mirrored frame.
- R4: High output of pair n equals floor((sum over k=-3..3 of g[k]*x[2n+1-k]) / 256). The coefficients are g[0]=285, g[±1]=-151, g[±2]=-15, g[±3]=23.
- R5: Before the frame start, samples mirror about the first sample: x[-k] = x[k].
- R6: Past the frame end, samples mirror about the last sample: x[N-1+k] = x[N-1-k].
- R7: `out_last` is high on the final pair of each frame only, and only together with `out_valid`.
- R8: Idle cycles (`in_valid` low) between samples of a frame do not change any output value.
- R9: The frame length is captured with the start flag, so back-to-back frames of different lengths are each filtered with their own length.
- R10: The cycle after a pair flagged last never carries a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample accepted this cycle |
| in_sof | input | 1 | Accepted sample is the first of a frame |
| in_len | input | $clog2(MAX_N+1) | Frame length, read when `in_sof` is high |
| in_data | input | DW | Signed two's-complement sample |
| out_valid | output | 1 | Output pair present |
| out_lo | output | DW+2 | Signed low-pass coefficient |
| out_hi | output | DW+2 | Signed high-pass coefficient |
| out_last | output | 1 | Pair is the last of its frame |

## Verification
The checker assumes that every start flag carries an even length of at least 8 that does not exceed MAX_N. It also assumes that each frame delivers exactly that many samples before the next start flag. The output range checks rely on the sample width alone, so they hold for any legal input values. The bench drives only complete, legal frames: some with idle gaps, some back to back, and one at both input extremes. A reference model of the mirrored convolution checks each pair value. A separate check confirms that the cycle after each last-flagged pair is empty.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;
  localparam int CW   = 12;  // coefficient width (scaled by 256)
  localparam int FRAC = 8;   // fraction bits removed at the output
  localparam int NWIN = 9;   // neighbourhood span of one output pair
  localparam int HALF = 4;   // window centre offset

  // even-position samples against even low-pass taps (k = 4,2,0,-2,-4)
  localparam logic [5*CW-1:0] LO_EVEN = {12'(7), 12'(-20), 12'(154), 12'(-20), 12'(7)};
  // odd-position samples against odd low-pass taps (k = 3,1,-1,-3)
  localparam logic [4*CW-1:0] LO_ODD  = {12'(-4), 12'(68), 12'(68), 12'(-4)};
  // odd-position samples against even high-pass taps (k = 2,0,-2)
  localparam logic [3*CW-1:0] HI_EVEN = {12'(-15), 12'(285), 12'(-15)};
  // even-position samples against odd high-pass taps (k = 3,1,-1,-3)
  localparam logic [4*CW-1:0] HI_ODD  = {12'(23), 12'(-151), 12'(-151), 12'(23)};
endpackage

// File: rtl/dwt97_da.sv
// Fully parallel distributed-arithmetic inner product with constant taps.
module dwt97_da #(
  parameter int NTAP = 4,
  parameter int DW   = 10,
  parameter int CW   = 12,
  parameter int ACW  = 26,
  parameter logic [NTAP*CW-1:0] COEF = '0
) (
  input  logic [NTAP*DW-1:0]     smp,
  output logic signed [ACW-1:0]  acc
);
  localparam int PW = CW + $clog2(NTAP + 1);

  function automatic logic signed [PW-1:0] lut(input logic [NTAP-1:0] addr);
    logic signed [PW-1:0] s;
    s = '0;
    for (int i = 0; i < NTAP; i++)
      if (addr[i]) s = s + PW'($signed(COEF[i*CW +: CW]));
    return s;
  endfunction

  logic signed [PW-1:0] part [DW];

  for (genvar b = 0; b < DW; b++) begin : g_plane
    logic [NTAP-1:0] addr;
    for (genvar i = 0; i < NTAP; i++) begin : g_addr
      assign addr[i] = smp[i*DW + b];
    end
    assign part[b] = lut(addr);
  end

  always_comb begin
    acc = '0;
    for (int b = 0; b < DW; b++) begin
      if (b == DW - 1) acc = acc - (ACW'(part[b]) <<< b);
      else             acc = acc + (ACW'(part[b]) <<< b);
    end
  end
endmodule

// File: rtl/dwt97_edge_mirror.sv
// Maps the nine taps of pair n onto stored samples, mirroring at frame edges.
module dwt97_edge_mirror #(
  parameter int DW   = 10,
  parameter int LW   = 7,
  parameter int NWIN = 9,
  parameter int HALF = 4
) (
  input  logic [NWIN*DW-1:0] win,   // slot q holds sample index (t - q)
  input  logic [LW-1:0]      pair,
  input  logic [LW-1:0]      newest,
  input  logic [LW-1:0]      len,
  output logic [NWIN*DW-1:0] taps   // tap i is sample 2*pair - HALF + i
);
  always_comb begin
    int j;
    int m;
    int q;
    taps = '0;
    for (int i = 0; i < NWIN; i++) begin
      j = 2 * int'(pair) - HALF + i;
      if (j < 0)                  m = -j;
      else if (j > int'(len) - 1) m = 2 * (int'(len) - 1) - j;
      else                        m = j;
      q = int'(newest) - m;
      if (q < 0 || q > NWIN - 1) q = 0;
      taps[i*DW +: DW] = win[q*DW +: DW];
    end
  end
endmodule

// File: rtl/dwt97_analysis.sv
module dwt97_analysis
  import dwt97_pkg::*;
#(
  parameter int DW    = 10,
  parameter int MAX_N = 64,
  localparam int LW   = $clog2(MAX_N + 1),
  localparam int OW   = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [LW-1:0] in_len,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_lo,
  output logic [OW-1:0] out_hi,
  output logic          out_last
);
  localparam int ACW = DW + CW + 4;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  // state
  logic [NWIN*DW-1:0] win_q, tail_q;
  logic [LW-1:0]      cnt_q, len_q;
  logic               job_vld_q, job_tail_q, job_end_q;
  logic [LW-1:0]      job_n_q, job_t_q, job_len_q;
  logic               ov_q, ol_q;
  logic [OW-1:0]      lo_q, hi_q;

  // next-state
  logic [LW-1:0]      t_cur, len_cur;
  logic               emit_mid, emit_end, tail_en;
  logic               job_vld_d, job_tail_d, job_end_d;
  logic [LW-1:0]      job_n_d, job_t_d, job_len_d;

  always_comb begin
    t_cur    = in_sof ? '0 : cnt_q + LW'(1);
    len_cur  = in_sof ? in_len : len_q;
    emit_mid = in_valid && !t_cur[0] && (t_cur >= LW'(HALF)) && (t_cur <= len_cur - LW'(2));
    emit_end = in_valid && (t_cur == len_cur - LW'(1));
    tail_en  = 1'b0;
    job_vld_d  = 1'b0;
    job_tail_d = 1'b0;
    job_end_d  = 1'b0;
    job_n_d    = job_n_q;
    job_t_d    = t_cur;
    job_len_d  = len_cur;
    if (emit_mid) begin
      job_vld_d = 1'b1;
      job_n_d   = (t_cur - LW'(HALF)) >> 1;
    end else if (emit_end) begin
      job_vld_d = 1'b1;
      job_end_d = 1'b1;
      job_n_d   = (len_cur >> 1) - LW'(2);
    end else if (job_vld_q && job_end_q) begin
      // last pair: computed from a frozen copy of the closing window
      tail_en    = 1'b1;
      job_vld_d  = 1'b1;
      job_tail_d = 1'b1;
      job_n_d    = job_n_q + LW'(1);
      job_t_d    = job_t_q;
      job_len_d  = job_len_q;
    end
  end

  // datapath
  logic [NWIN*DW-1:0]   src, taps;
  logic signed [ACW-1:0] lo_e, lo_o, hi_e, hi_o, lo_sum, hi_sum;

  assign src = job_tail_q ? tail_q : win_q;

  dwt97_edge_mirror #(.DW(DW), .LW(LW), .NWIN(NWIN), .HALF(HALF)) i_mirror (
    .win(src), .pair(job_n_q), .newest(job_t_q), .len(job_len_q), .taps(taps)
  );

  dwt97_da #(.NTAP(5), .DW(DW), .CW(CW), .ACW(ACW), .COEF(LO_EVEN)) i_lo_even (
    .smp({taps[8*DW +: DW], taps[6*DW +: DW], taps[4*DW +: DW], taps[2*DW +: DW], taps[0 +: DW]}),
    .acc(lo_e)
  );
  dwt97_da #(.NTAP(4), .DW(DW), .CW(CW), .ACW(ACW), .COEF(LO_ODD)) i_lo_odd (
    .smp({taps[7*DW +: DW], taps[5*DW +: DW], taps[3*DW +: DW], taps[1*DW +: DW]}),
    .acc(lo_o)
  );
  dwt97_da #(.NTAP(3), .DW(DW), .CW(CW), .ACW(ACW), .COEF(HI_EVEN)) i_hi_even (
    .smp({taps[7*DW +: DW], taps[5*DW +: DW], taps[3*DW +: DW]}),
    .acc(hi_e)
  );
  dwt97_da #(.NTAP(4), .DW(DW), .CW(CW), .ACW(ACW), .COEF(HI_ODD)) i_hi_odd (
    .smp({taps[8*DW +: DW], taps[6*DW +: DW], taps[4*DW +: DW], taps[2*DW +: DW]}),
    .acc(hi_o)
  );

  assign lo_sum = lo_e + lo_o;
  assign hi_sum = hi_e + hi_o;

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      win_q      <= '0;
      tail_q     <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
      job_vld_q  <= 1'b0;
      job_tail_q <= 1'b0;
      job_end_q  <= 1'b0;
      job_n_q    <= '0;
      job_t_q    <= '0;
      job_len_q  <= '0;
      ov_q       <= 1'b0;
      ol_q       <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else begin
      if (in_valid) begin
        win_q <= {win_q[(NWIN-1)*DW-1:0], in_data};
        cnt_q <= t_cur;
        len_q <= len_cur;
      end
      if (tail_en) tail_q <= win_q;
      job_vld_q  <= job_vld_d;
      job_tail_q <= job_tail_d;
      job_end_q  <= job_end_d;
      if (job_vld_d) begin
        job_n_q   <= job_n_d;
        job_t_q   <= job_t_d;
        job_len_q <= job_len_d;
      end
      ov_q <= job_vld_q;
      ol_q <= job_vld_q && (job_n_q == (job_len_q >> 1) - LW'(1));
      if (job_vld_q) begin
        lo_q <= OW'(lo_sum >>> FRAC);
        hi_q <= OW'(hi_sum >>> FRAC);
      end
    end
  end

  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_lo    = lo_q;
  assign out_hi    = hi_q;
endmodule

// File: rtl/dwt97_analysis_chk.sv
module dwt97_analysis_chk #(
  parameter int DW    = 10,
  parameter int MAX_N = 64,
  localparam int LW   = $clog2(MAX_N + 1),
  localparam int OW   = DW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic [LW-1:0] in_len,
  input logic          out_valid,
  input logic [OW-1:0] out_lo,
  input logic [OW-1:0] out_hi,
  input logic          out_last
);
  localparam int LO_MAX = ((352 << (DW - 1)) >> 8) + 1;
  localparam int HI_MAX = ((663 << (DW - 1)) >> 8) + 1;

  // R9
  frame_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |-> (in_len >= LW'(8)) && !in_len[0] && (int'(in_len) <= MAX_N));

  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R10
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  // R2
  output_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2) || $past(out_valid));

  // R3
  lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_lo) <= LO_MAX) && ($signed(out_lo) >= -LO_MAX));

  // R4
  hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_hi) <= HI_MAX) && ($signed(out_hi) >= -HI_MAX));
endmodule

bind dwt97_analysis dwt97_analysis_chk #(.DW(DW), .MAX_N(MAX_N)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_len(in_len),
  .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi), .out_last(out_last)
);

// File: tb/test_dwt97_analysis.sv
`timescale 1ns/1ps
module test_dwt97_analysis;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 10;
  localparam int MAX_N = 64;
  localparam int LW    = $clog2(MAX_N + 1);
  localparam int OW    = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [LW-1:0] in_len = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_last;
  logic [OW-1:0] out_lo, out_hi;

  dwt97_analysis #(.DW(DW), .MAX_N(MAX_N)) i_dwt97_analysis (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_len(in_len),
    .in_data(in_data), .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
    .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int stim [256];
  int obs_lo [128];
  int obs_hi [128];
  bit obs_last [128];
  int obs_cnt = 0;
  bit prev_last = 0;
  int lcg = 12345;

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (prev_last) begin
      checks++;
      if (out_valid) begin
        errors++;
        $display("FAIL R10 valid after last: actual %0d expected 0", out_valid);
      end
    end
    prev_last = out_valid && out_last;
    if (out_valid && obs_cnt < 128) begin
      obs_lo[obs_cnt]   = int'($signed(out_lo));
      obs_hi[obs_cnt]   = int'($signed(out_hi));
      obs_last[obs_cnt] = out_last;
      obs_cnt++;
    end else if (out_valid) obs_cnt++;
  end

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h7fff;
  endfunction

  function automatic int xm(int base, int n, int j);
    int m;
    m = j;
    if (m < 0) m = -m;
    if (m > n - 1) m = 2 * (n - 1) - m;
    return stim[base + m];
  endfunction

  function automatic int hco(int k);
    case (k < 0 ? -k : k)
      0: return 154; 1: return 68; 2: return -20; 3: return -4; 4: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int gco(int k);
    case (k < 0 ? -k : k)
      0: return 285; 1: return -151; 2: return -15; 3: return 23;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_lo(int base, int n, int p);
    int acc;
    acc = 0;
    for (int k = -4; k <= 4; k++) acc += hco(k) * xm(base, n, 2 * p - k);
    return acc >>> 8;
  endfunction

  function automatic int ref_hi(int base, int n, int p);
    int acc;
    acc = 0;
    for (int k = -3; k <= 3; k++) acc += gco(k) * xm(base, n, 2 * p + 1 - k);
    return acc >>> 8;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_frame(input int base, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        for (int g = next_rand() % 3; g > 0; g--) begin
          in_valid = 1'b0;
          @(posedge clk); #1;
        end
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_len   = LW'(n);
      in_data  = DW'(stim[base + i]);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // compare frame outputs at obs offset o against the model; tag labels the scenario
  task automatic check_frame(input int o, input int base, input int n, input string tag);
    for (int p = 0; p < n / 2; p++) begin
      string rl, rh;
      rl = (p == 0) ? "R5 lo" : (p == n / 2 - 1) ? "R6 lo" : "R3 lo";
      rh = (p == 0) ? "R5 hi" : (p == n / 2 - 1) ? "R6 hi" : "R4 hi";
      check({tag, " ", rl}, obs_lo[o + p], ref_lo(base, n, p));
      check({tag, " ", rh}, obs_hi[o + p], ref_hi(base, n, p));
      check({tag, " R7 last"}, int'(obs_last[o + p]), (p == n / 2 - 1) ? 1 : 0);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    idle(3);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    idle(6);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 last after reset", int'(out_last), 0);
  endtask

  task automatic test_ramp();
    for (int i = 0; i < 8; i++) stim[i] = 30 * i - 100;
    obs_cnt = 0;
    drive_frame(0, 8, 0);
    idle(8);
    check("R2 ramp pair count", obs_cnt, 4);
    check_frame(0, 0, 8, "ramp");
  endtask

  task automatic test_edges();
    for (int i = 0; i < 12; i++) stim[i] = 0;
    stim[0]  = 200;
    stim[1]  = -90;
    stim[11] = -300;
    stim[10] = 150;
    obs_cnt = 0;
    drive_frame(0, 12, 0);
    idle(8);
    check("R2 edge pair count", obs_cnt, 6);
    check_frame(0, 0, 12, "edges");
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 16; i++) stim[i] = (next_rand() % 1024) - 512;
    obs_cnt = 0;
    drive_frame(0, 16, 1);
    idle(8);
    check("R8 gapped pair count", obs_cnt, 8);
    check_frame(0, 0, 16, "R8 gaps");
  endtask

  task automatic test_back_to_back();
    for (int i = 0; i < 32; i++) stim[i] = ((i * 37) % 200) - 100;
    obs_cnt = 0;
    drive_frame(0, 8, 0);
    drive_frame(8, 14, 0);
    drive_frame(22, 10, 0);
    idle(8);
    check("R9 total pair count", obs_cnt, 16);
    check_frame(0, 0, 8, "R9 f0");
    check_frame(4, 8, 14, "R9 f1");
    check_frame(11, 22, 10, "R9 f2");
  endtask

  task automatic test_extremes();
    for (int i = 0; i < 10; i++) stim[i] = (i % 2 == 0) ? 511 : -512;
    for (int i = 10; i < 20; i++) stim[i] = -512;
    obs_cnt = 0;
    drive_frame(0, 10, 0);
    drive_frame(10, 10, 0);
    idle(8);
    check("R2 extreme pair count", obs_cnt, 10);
    check_frame(0, 0, 10, "R4 alt");
    check_frame(5, 10, 10, "R3 min");
  endtask

  initial begin
    idle(2);
    test_reset();
    test_ramp();
    test_edges();
    test_gaps();
    test_back_to_back();
    test_extremes();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule